// File: doc/BRIEF.md
# Hotplug Slot Status Register Block

This block keeps per-bus records of device insertion and removal requests and shows them to firmware through a small register window of 32-bit words. Each bus has 32 slots. A slot's bit in the "arrived" bitmap is set by a plug strobe. A slot's bit in the "leaving" bitmap is set by an unplug-request strobe. Either strobe raises a one-cycle event pulse toward firmware.

Firmware works through one selected bus at a time.
- Reading the arrived bitmap clears it, except in legacy mode.
- Writing a slot mask to the eject word acts on the lowest set slot. It clears that slot's pending bits and emits an eject strobe that carries the bus and slot.
- Writing a slot mask to the index word latches a per-slot index from an external lookup. A later read returns the latched value once.

A platform reset does not wipe the pending state. Instead it drains every outstanding removal one slot per cycle through the eject strobe. It then reloads each bus's removable bitmap from the fixed-slot mask. Power-on reset clears the state and runs the same sequence.

Top module: `hotplug_status_regs`

## Requirements
- R1: After `rst_n` is released and the drain finishes, these reads return zero: the bus select (offset 0x10) and the arrived bitmap (0x00) and leaving bitmap (0x04) of every bus. The removable bitmap (0x0C) of bus b reads as the bitwise inverse of `fixed_slots[32*b +: 32]`. No strobe is active.
- R2: A `hp_plug` strobe sets bit `hp_slot` of bus `hp_bus`'s arrived bitmap. `event_pulse` is high in the following cycle.
- R3: A `hp_unplug` strobe sets the slot's bit in the leaving bitmap. `event_pulse` is high in the following cycle.
- R4: A read of offset 0x00 returns the selected bus's arrived bitmap and then clears it. While `legacy` is 1 the bitmap is not cleared.
- R5: A read returns its data in `reg_rdata`, with `reg_rvalid` high, one cycle after `reg_rd`. A read of offset 0x08 always returns zero.
- R6: A write to 0x08 with nonzero data takes the lowest set bit as the slot. It clears that slot's bit in both bitmaps of the selected bus. In the next cycle it pulses `ej_stb` with `ej_bus` and `ej_slot`. Data of zero does nothing.
- R7: While the bus select value is NBUS or more, every read returns zero and writes to 0x08 and 0x14 have no effect.
- R8: A write to 0x10 stores the data. While `legacy` is 1 the stored value is 0.
- R9: Every accepted write clears the latched index. A write to 0x14 with nonzero data then latches `lk_index`, where `lk_bus` is the selected bus and `lk_slot` is the lowest set data bit. A read of 0x14 returns the latch and clears it.
- R10: After a `sys_reset` pulse or `rst_n`, the buses are walked in ascending order. Each pending leaving bit is ejected lowest slot first, one per cycle, through `ej_stb`, clearing its bits in both bitmaps. After that the removable bitmap is loaded. While this runs, writes are ignored and reads return zero.
- R11: A plug or unplug strobe in the same cycle as a clearing read or eject on the same bus is not lost: the set bit survives.
- R12: An access whose offset is not a multiple of 4, or is 0x18 or above, changes nothing and reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears state, then starts a drain |
| legacy | input | 1 | Legacy mode: arrived bitmap not cleared on read, bus select pinned to 0 |
| sys_reset | input | 1 | Platform reset pulse; starts a drain of pending removals |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset in the window |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| reg_rdata | output | 32 | Read data |
| hp_plug | input | 1 | Device arrived on `hp_bus`/`hp_slot` |
| hp_unplug | input | 1 | Removal requested on `hp_bus`/`hp_slot` |
| hp_bus | input | BW | Bus of the strobe |
| hp_slot | input | 5 | Slot of the strobe |
| fixed_slots | input | NBUS*32 | Per-slot non-removable marks, 32 bits per bus |
| lk_bus | output | BW | Bus for index lookup |
| lk_slot | output | 5 | Slot for index lookup |
| lk_index | input | IDXW | Looked-up index value |
| event_pulse | output | 1 | One-cycle notification to firmware |
| ej_stb | output | 1 | Eject strobe |
| ej_bus | output | BW | Bus of the ejected slot |
| ej_slot | output | 5 | Ejected slot |

## Verification
The hardest case to reach is a drain that must walk a backlog. The bench creates pending removals on two non-adjacent buses, with an arrived bit overlapping one of them, and then pulses `sys_reset`. It records every eject strobe and compares the bus and slot order with a list worked out by hand. It also places a read inside the drain window to show that the read comes back as zero. The same-cycle collisions are reached by driving a strobe and a register access on the same falling edge. One case is a plug during a clearing read. The other is an unplug of the very slot being ejected.

// File: rtl/hotplug_status_regs.sv
module hotplug_status_regs #(
  parameter int NBUS = 4,
  parameter int IDXW = 14,
  localparam int BW = (NBUS > 1) ? $clog2(NBUS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               legacy,
  input  logic               sys_reset,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [4:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic               reg_rvalid,
  output logic [31:0]        reg_rdata,
  input  logic               hp_plug,
  input  logic               hp_unplug,
  input  logic [BW-1:0]      hp_bus,
  input  logic [4:0]         hp_slot,
  input  logic [NBUS*32-1:0] fixed_slots,
  output logic [BW-1:0]      lk_bus,
  output logic [4:0]         lk_slot,
  input  logic [IDXW-1:0]    lk_index,
  output logic               event_pulse,
  output logic               ej_stb,
  output logic [BW-1:0]      ej_bus,
  output logic [4:0]         ej_slot
);

  function automatic logic [5:0] low_bit(input logic [31:0] v);
    low_bit = 6'd32;
    for (int i = 31; i >= 0; i--)
      if (v[i]) low_bit = 6'(i);
  endfunction

  logic [31:0]     up_q [NBUS];
  logic [31:0]     dn_q [NBUS];
  logic [31:0]     rm_q [NBUS];
  logic [31:0]     up_n [NBUS];
  logic [31:0]     dn_n [NBUS];
  logic [31:0]     rm_n [NBUS];
  logic [31:0]     sel_q;
  logic [IDXW-1:0] idx_q;
  logic            drain_q;
  logic [BW-1:0]   dbus_q;
  logic [31:0]     rdata_n;

  wire          aligned = (reg_addr[1:0] == 2'b00) && (reg_addr < 5'h18);
  wire [2:0]    word    = reg_addr[4:2];
  wire          acc_ok  = aligned && !drain_q;
  wire          do_wr   = reg_wr && acc_ok;
  wire          do_rd   = reg_rd && acc_ok;
  wire          sel_ok  = sel_q < 32'(NBUS);
  wire [BW-1:0] sbus    = sel_q[BW-1:0];
  wire [5:0]    wslot   = low_bit(reg_wdata);
  wire [5:0]    dslot   = low_bit(dn_q[dbus_q]);
  wire          ej_req  = do_wr && word == 3'd2 && sel_ok && !wslot[5];
  wire          drain_ej   = drain_q && !dslot[5];
  wire          drain_next = drain_q && dslot[5];
  wire          up_rdclr   = do_rd && word == 3'd0 && sel_ok && !legacy;

  assign lk_bus  = sbus;
  assign lk_slot = wslot[4:0];

  always_comb begin
    for (int b = 0; b < NBUS; b++) begin
      logic [31:0] clr;
      clr = '0;
      if (ej_req && sbus == BW'(b)) clr[wslot[4:0]] = 1'b1;
      if (drain_ej && dbus_q == BW'(b)) clr[dslot[4:0]] = 1'b1;
      up_n[b] = up_q[b] & ~clr;
      if (up_rdclr && sbus == BW'(b)) up_n[b] = '0;
      dn_n[b] = dn_q[b] & ~clr;
      if (hp_plug && hp_bus == BW'(b)) up_n[b][hp_slot] = 1'b1;
      if (hp_unplug && hp_bus == BW'(b)) dn_n[b][hp_slot] = 1'b1;
      rm_n[b] = rm_q[b];
      if (drain_next && dbus_q == BW'(b)) rm_n[b] = ~fixed_slots[b*32 +: 32];
    end
  end

  always_comb begin
    rdata_n = '0;
    if (do_rd && sel_ok) begin
      case (word)
        3'd0:    rdata_n = up_q[sbus];
        3'd1:    rdata_n = dn_q[sbus];
        3'd3:    rdata_n = rm_q[sbus];
        3'd4:    rdata_n = sel_q;
        3'd5:    rdata_n = 32'(idx_q);
        default: rdata_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBUS; b++) begin
        up_q[b] <= '0;
        dn_q[b] <= '0;
        rm_q[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NBUS; b++) begin
        up_q[b] <= up_n[b];
        dn_q[b] <= dn_n[b];
        rm_q[b] <= rm_n[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_q <= 1'b1;
      dbus_q  <= '0;
    end else if (sys_reset) begin
      drain_q <= 1'b1;
      dbus_q  <= '0;
    end else if (drain_next) begin
      if (dbus_q == BW'(NBUS - 1)) drain_q <= 1'b0;
      else dbus_q <= dbus_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      idx_q <= '0;
    end else begin
      if (do_wr && word == 3'd4) sel_q <= legacy ? 32'd0 : reg_wdata;
      if (do_wr)
        idx_q <= (word == 3'd5 && sel_ok && !wslot[5]) ? lk_index : '0;
      else if (do_rd && word == 3'd5 && sel_ok)
        idx_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid  <= 1'b0;
      reg_rdata   <= '0;
      event_pulse <= 1'b0;
      ej_stb      <= 1'b0;
      ej_bus      <= '0;
      ej_slot     <= '0;
    end else begin
      reg_rvalid  <= reg_rd;
      reg_rdata   <= rdata_n;
      event_pulse <= hp_plug | hp_unplug;
      ej_stb      <= ej_req | drain_ej;
      ej_bus      <= drain_ej ? dbus_q : sbus;
      ej_slot     <= drain_ej ? dslot[4:0] : wslot[4:0];
    end
  end

  // R2
  a_r2_plug_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hp_plug |=> up_q[$past(hp_bus)][$past(hp_slot)]);
  // R3
  a_r3_unplug_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hp_unplug |=> dn_q[$past(hp_bus)][$past(hp_slot)]);
  // R5
  a_r5_eject_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rvalid && $past(reg_addr) == 5'h08) |-> reg_rdata == 32'd0);
  // R6
  a_r6_eject_clears_up: assert property (@(posedge clk) disable iff (!rst_n)
    (ej_stb && !($past(hp_plug) && $past(hp_bus) == ej_bus && $past(hp_slot) == ej_slot))
      |-> !up_q[ej_bus][ej_slot]);
  a_r6_eject_clears_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (ej_stb && !($past(hp_unplug) && $past(hp_bus) == ej_bus && $past(hp_slot) == ej_slot))
      |-> !dn_q[ej_bus][ej_slot]);
  // R7
  a_r7_bad_sel_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rvalid && $past(sel_q) >= 32'(NBUS)) |-> reg_rdata == 32'd0);
  // R8
  a_r8_legacy_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr) && $past(legacy) && $past(reg_addr) == 5'h10) |-> sel_q == 32'd0);
  // R10
  a_r10_drain_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rvalid && $past(drain_q)) |-> reg_rdata == 32'd0);

endmodule

// File: tb/hotplug_status_regs_test.sv
module hotplug_status_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int NBUS = 4;
  localparam int IDXW = 14;
  localparam int BW = 2;

  logic clk = 0, rst_n = 0, legacy = 0, sys_reset = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic reg_rvalid;
  logic [31:0] reg_rdata;
  logic hp_plug = 0, hp_unplug = 0;
  logic [BW-1:0] hp_bus = 0;
  logic [4:0] hp_slot = 0;
  logic [NBUS*32-1:0] fixed_slots;
  logic [BW-1:0] lk_bus, ej_bus;
  logic [4:0] lk_slot, ej_slot;
  logic [IDXW-1:0] lk_index;
  logic event_pulse, ej_stb;

  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [IDXW-1:0] idx_of(input int b, input int s);
    return IDXW'(b * 100 + s + 1);
  endfunction
  function automatic int first_one(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 32;
  endfunction

  assign lk_index = idx_of(int'(lk_bus), int'(lk_slot));
  always_comb
    for (int k = 0; k < NBUS * 32; k++)
      fixed_slots[k] = (((k % 32) * 3 + k / 32) % 7) == 0;

  hotplug_status_regs #(.NBUS(NBUS), .IDXW(IDXW)) uut (
    .clk(clk), .rst_n(rst_n), .legacy(legacy), .sys_reset(sys_reset),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .hp_plug(hp_plug), .hp_unplug(hp_unplug), .hp_bus(hp_bus), .hp_slot(hp_slot),
    .fixed_slots(fixed_slots), .lk_bus(lk_bus), .lk_slot(lk_slot), .lk_index(lk_index),
    .event_pulse(event_pulse), .ej_stb(ej_stb), .ej_bus(ej_bus), .ej_slot(ej_slot));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
    chk(reg_rdata, exp, tag);
  endtask
  task automatic strobe(input bit unp, input int b, input int s);
    @(negedge clk); hp_plug = !unp; hp_unplug = unp; hp_bus = BW'(b); hp_slot = 5'(s);
    @(negedge clk); hp_plug = 0; hp_unplug = 0;
  endtask

  int ev_n = 0;
  int ev_bus [8];
  int ev_slot [8];
  bit log_en = 0;
  always @(negedge clk)
    if (log_en && ej_stb && ev_n < 8) begin
      ev_bus[ev_n] = int'(ej_bus); ev_slot[ev_n] = int'(ej_slot); ev_n++;
    end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] m, rem, d;
    int es;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (8) @(negedge clk);
    // R1 reset state
    chk({31'd0, ej_stb}, 0, "R1 ej_stb idle");
    chk({31'd0, event_pulse}, 0, "R1 event idle");
    rd(5'h10, 0, "R1 sel reset");
    for (int b = 0; b < NBUS; b++) begin
      wr(5'h10, b);
      rd(5'h00, 0, "R1 up reset");
      rd(5'h04, 0, "R1 down reset");
      rd(5'h0C, ~fixed_slots[b*32 +: 32], "R1 removable reset");
    end
    // R5 latency and eject read
    @(negedge clk); reg_rd = 1; reg_addr = 5'h08;
    @(negedge clk); reg_rd = 0;
    chk({31'd0, reg_rvalid}, 1, "R5 rvalid after read");
    chk(reg_rdata, 0, "R5 eject read zero");
    @(negedge clk);
    chk({31'd0, reg_rvalid}, 0, "R5 rvalid single");

    // R2 / R4 sweep every bus and slot
    for (int b = 0; b < NBUS; b++) begin
      wr(5'h10, b);
      for (int s = 0; s < 32; s++) begin
        strobe(0, b, s);
        chk({31'd0, event_pulse}, 1, "R2 plug event");
        rd(5'h00, 32'd1 << s, "R4 up read value");
        rd(5'h00, 0, "R4 up cleared by read");
      end
    end

    // R3 / R6 unplug and eject sweep
    for (int b = 0; b < NBUS; b++) begin
      m = 32'h9A5C_3E81 ^ (32'h1111_1111 * b);
      wr(5'h10, b);
      for (int s = 0; s < 32; s++)
        if (m[s]) begin
          strobe(1, b, s);
          chk({31'd0, event_pulse}, 1, "R3 unplug event");
          strobe(0, b, s);
        end
      rd(5'h04, m, "R3 down bitmap");
      wr(5'h08, 0);
      chk({31'd0, ej_stb}, 0, "R6 zero eject no strobe");
      rd(5'h04, m, "R6 zero eject keeps down");
      rem = m;
      while (rem != 0) begin
        es = first_one(rem);
        d = rem | 32'h8000_0000;
        wr(5'h08, d);
        chk({31'd0, ej_stb}, 1, "R6 eject strobe");
        chk(32'(ej_bus), b, "R6 eject bus");
        chk(32'(ej_slot), es, "R6 eject lowest slot");
        rem[es] = 1'b0;
        rd(5'h04, rem, "R6 down after eject");
      end
      rd(5'h00, 0, "R6 up cleared by ejects");
    end

    // R9 index latch
    wr(5'h10, 2);
    wr(5'h14, (32'd1 << 5) | (32'd1 << 9));
    rd(5'h14, 32'(idx_of(2, 5)), "R9 index latched");
    rd(5'h14, 0, "R9 index cleared by read");
    wr(5'h14, 32'd1 << 17);
    wr(5'h10, 2);
    rd(5'h14, 0, "R9 index cleared by other write");
    wr(5'h14, 0);
    rd(5'h14, 0, "R9 zero mask no index");

    // R7 out-of-range select
    strobe(1, 3, 4);
    wr(5'h10, 7);
    rd(5'h10, 0, "R7 sel read zero");
    wr(5'h08, 32'd1 << 4);
    chk({31'd0, ej_stb}, 0, "R7 eject ignored");
    wr(5'h14, 32'd1 << 4);
    wr(5'h10, 3);
    rd(5'h04, 32'd1 << 4, "R7 down untouched");
    wr(5'h08, 32'd1 << 4);

    // R12 misaligned and outside window
    wr(5'h11, 1);
    rd(5'h10, 3, "R12 misaligned write ignored");
    rd(5'h12, 0, "R12 misaligned read zero");
    rd(5'h18, 0, "R12 out-of-window read zero");

    // R8 / R4 legacy
    legacy = 1;
    wr(5'h10, 3);
    rd(5'h10, 0, "R8 legacy sel forced zero");
    strobe(0, 0, 2);
    rd(5'h00, 32'd1 << 2, "R4 legacy up read");
    rd(5'h00, 32'd1 << 2, "R4 legacy up kept");
    legacy = 0;
    rd(5'h00, 32'd1 << 2, "R4 up read");
    rd(5'h00, 0, "R4 up cleared");
    wr(5'h10, 3);
    rd(5'h10, 3, "R8 sel stored");

    // R11 set wins over clear
    wr(5'h10, 1);
    strobe(0, 1, 4);
    @(negedge clk); reg_rd = 1; reg_addr = 5'h00; hp_plug = 1; hp_bus = 1; hp_slot = 6;
    @(negedge clk); reg_rd = 0; hp_plug = 0;
    chk(reg_rdata, 32'd1 << 4, "R11 read during plug");
    rd(5'h00, 32'd1 << 6, "R11 plug survived read clear");
    strobe(1, 1, 9);
    @(negedge clk); reg_wr = 1; reg_addr = 5'h08; reg_wdata = 32'd1 << 9;
    hp_unplug = 1; hp_bus = 1; hp_slot = 9;
    @(negedge clk); reg_wr = 0; hp_unplug = 0;
    chk({31'd0, ej_stb}, 1, "R11 eject strobe");
    rd(5'h04, 32'd1 << 9, "R11 unplug survived eject");
    wr(5'h08, 32'd1 << 9);

    // R10 drain
    strobe(1, 1, 7);
    strobe(1, 1, 3);
    strobe(0, 1, 3);
    strobe(1, 3, 0);
    log_en = 1;
    @(negedge clk); sys_reset = 1;
    @(negedge clk); sys_reset = 0;
    rd(5'h0C, 0, "R10 read during drain zero");
    repeat (12) @(negedge clk);
    log_en = 0;
    chk(ev_n, 3, "R10 drain eject count");
    chk(ev_bus[0], 1, "R10 first bus");  chk(ev_slot[0], 3, "R10 first slot");
    chk(ev_bus[1], 1, "R10 second bus"); chk(ev_slot[1], 7, "R10 second slot");
    chk(ev_bus[2], 3, "R10 third bus");  chk(ev_slot[2], 0, "R10 third slot");
    wr(5'h10, 1);
    rd(5'h04, 0, "R10 bus1 down drained");
    rd(5'h00, 0, "R10 bus1 up cleared");
    for (int b = 0; b < NBUS; b++) begin
      wr(5'h10, b);
      rd(5'h0C, ~fixed_slots[b*32 +: 32], "R10 removable reload");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule